// File: doc/BRIEF.md
# Non-Blocking State-Message Mailbox

This block is a small message FIFO placed between event-driven producers and two kinds of consumer. An event-driven consumer reads through a blocking port. That port uses a valid/ready handshake and simply waits while nothing is queued. A time-driven consumer reads through a second port that must never stall. Every request on that port is answered exactly one cycle later.

When the queue holds a message, a request on the non-blocking port dequeues the head. A keeper register retains a copy of that message. When the queue is empty, the keeper copy is returned instead, and a fresh flag tells the consumer which case it received. The keeper therefore acts as the latest known state for periodic tasks. Only dequeues through the non-blocking port refresh it.

A single write port feeds the queue. A write is taken only while the queue is not full, and the full flag is visible to the producer so that it can hold the message instead of losing it.

Top module: `state_mailbox`

## Requirements
- R1: While the queue is empty, `bq_valid` stays low whatever `bq_ready` does. A message written in cycle n makes `bq_valid` high after the edge that ends cycle n.
- R2: A blocking dequeue happens on each edge where `bq_valid` and `bq_ready` are both high. `bq_data` presents messages in the order they were written.
- R3: A `nb_req` while the queue holds data, and with no blocking dequeue in the same cycle, removes the head message. After the next edge it is returned on `nb_rsp_data` with `nb_rsp_fresh` = 1.
- R4: Each dequeue through the non-blocking port loads the keeper with the dequeued message and sets `keep_valid` to 1.
- R5: A `nb_req` on an empty queue returns the keeper contents with `nb_rsp_fresh` = 0 and leaves the queue unchanged.
- R6: After reset the queue is empty, `keep_valid` is 0 and the keeper holds the parameter `KEEP_RST`. A non-blocking read before any non-blocking dequeue returns that value.
- R7: When a blocking dequeue and a `nb_req` occur in the same cycle, the blocking port takes the head. The non-blocking port gets the keeper with `nb_rsp_fresh` = 0, and the head is consumed only once.
- R8: `wr_full` is high while `DEPTH` messages are held. A write presented while `wr_full` is high is refused and the queued messages are unchanged.
- R9: `nb_rsp_valid` is high in exactly the cycle after each `nb_req` and low otherwise.
- R10: Blocking dequeues leave the keeper contents and `keep_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Message to enqueue |
| wr_full | output | 1 | Queue full; a write is refused while high |
| bq_valid | output | 1 | Blocking port: head message present |
| bq_data | output | W | Blocking port: head message |
| bq_ready | input | 1 | Blocking port: consumer takes the head |
| nb_req | input | 1 | Non-blocking read request |
| nb_rsp_valid | output | 1 | Non-blocking response, one cycle after the request |
| nb_rsp_data | output | W | Non-blocking response data |
| nb_rsp_fresh | output | 1 | 1 = data came from the queue, 0 = from the keeper |
| keep_valid | output | 1 | Keeper has been loaded since reset |

## Verification
The assertions check several rules on every cycle. A rising blocking valid must follow a write. A refused write must not change the occupancy. A non-blocking request with data and no competing dequeue must return the old head marked fresh. On an empty queue, or when the blocking port competes, the response must be the stale keeper. A blocking dequeue must leave the keeper still. Only the bench scenarios show ordering across a full fill and drain, which messages survive a refused write, and the interleaving of both ports over long sequences. The same holds for the keeper's reset value reappearing after a second reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // source chosen for a non-blocking response
  typedef enum logic [1:0] {
    NB_NONE = 2'd0,
    NB_FIFO = 2'd1,
    NB_KEEP = 2'd2
  } nb_src_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q)) && full); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH))); // R8
endmodule

// File: rtl/mbox_arb.sv
module mbox_arb
  import mbox_pkg::*;
(
  input  logic    empty,
  input  logic    bq_ready,
  input  logic    nb_req,
  output logic    bq_pop,
  output logic    nb_pop,
  output nb_src_e nb_src
);
  always_comb begin
    bq_pop = !empty && bq_ready;
    nb_pop = 1'b0;
    nb_src = NB_NONE;
    if (nb_req) begin
      if (!empty && !bq_pop) begin
        nb_pop = 1'b1;
        nb_src = NB_FIFO;
      end else begin
        nb_src = NB_KEEP;
      end
    end
  end
endmodule

// File: rtl/mbox_keeper.sv
module mbox_keeper #(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         vld
);
  logic [W-1:0] q_d;
  logic         vld_d;

  always_comb begin
    q_d   = q;
    vld_d = vld;
    if (load) begin
      q_d   = din;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST;
      vld <= 1'b0;
    end else begin
      q   <= q_d;
      vld <= vld_d;
    end
  end
endmodule

// File: rtl/mbox_nb_rsp.sv
module mbox_nb_rsp
  import mbox_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  nb_src_e      src,
  input  logic [W-1:0] fifo_data,
  input  logic [W-1:0] keep_data,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data,
  output logic         rsp_fresh
);
  logic         en;
  logic [W-1:0] data_d;
  logic         fresh_d;

  always_comb begin
    en      = (src != NB_NONE);
    fresh_d = (src == NB_FIFO);
    data_d  = fresh_d ? fifo_data : keep_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fresh <= 1'b0;
    end else begin
      rsp_valid <= en;
      if (en) begin
        rsp_data  <= data_d;
        rsp_fresh <= fresh_d;
      end
    end
  end
endmodule

// File: rtl/state_mailbox.sv
module state_mailbox
  import mbox_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           DEPTH    = 4,
  parameter logic [W-1:0] KEEP_RST = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_full,
  output logic         bq_valid,
  output logic [W-1:0] bq_data,
  input  logic         bq_ready,
  input  logic         nb_req,
  output logic         nb_rsp_valid,
  output logic [W-1:0] nb_rsp_data,
  output logic         nb_rsp_fresh,
  output logic         keep_valid
);
  logic         rst_n;
  logic         empty, bq_pop, nb_pop;
  logic [W-1:0] head, keep_q;
  nb_src_e      nb_src;

  mbox_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  mbox_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(bq_pop || nb_pop), .head(head), .empty(empty), .full(wr_full)
  );

  mbox_arb u_arb (
    .empty(empty), .bq_ready(bq_ready), .nb_req(nb_req),
    .bq_pop(bq_pop), .nb_pop(nb_pop), .nb_src(nb_src)
  );

  mbox_keeper #(.W(W), .RST(KEEP_RST)) u_keep (
    .clk(clk), .rst_n(rst_n), .load(nb_pop), .din(head),
    .q(keep_q), .vld(keep_valid)
  );

  mbox_nb_rsp #(.W(W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .src(nb_src), .fifo_data(head),
    .keep_data(keep_q), .rsp_valid(nb_rsp_valid), .rsp_data(nb_rsp_data),
    .rsp_fresh(nb_rsp_fresh)
  );

  assign bq_valid = !empty;
  assign bq_data  = head;

  AST_VALID_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bq_valid) |-> $past(wr_en)); // R1
  AST_NB_FRESH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_req && bq_valid && !bq_ready) |=>
      (nb_rsp_fresh && nb_rsp_data == $past(bq_data) && keep_valid)); // R3
  AST_NB_EMPTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_req && !bq_valid) |=> (!nb_rsp_fresh && nb_rsp_data == $past(keep_q))); // R5
  AST_BLOCKING_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_req && bq_valid && bq_ready) |=> (!nb_rsp_fresh && nb_rsp_valid)); // R7
  AST_BQ_KEEPS_KEEPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bq_valid && bq_ready) |=> ($stable(keep_q) && $stable(keep_valid))); // R10
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !nb_req |=> !nb_rsp_valid); // R9
endmodule

// File: tb/state_mailbox_bench.sv
module state_mailbox_bench;
  localparam int          W    = 16;
  localparam int          D    = 4;
  localparam logic [15:0] KRST = 16'h00C3;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         wr_en, bq_ready, nb_req;
  logic [W-1:0] wr_data;
  logic         wr_full, bq_valid, nb_rsp_valid, nb_rsp_fresh, keep_valid;
  logic [W-1:0] bq_data, nb_rsp_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  state_mailbox #(.W(W), .DEPTH(D), .KEEP_RST(KRST)) u_state_mailbox (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .bq_valid(bq_valid), .bq_data(bq_data),
    .bq_ready(bq_ready), .nb_req(nb_req), .nb_rsp_valid(nb_rsp_valid),
    .nb_rsp_data(nb_rsp_data), .nb_rsp_fresh(nb_rsp_fresh),
    .keep_valid(keep_valid)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] wd;
    logic        rdy;
    logic        nb;
    logic        e_bv;
    logic [15:0] e_bd;
    logic        e_full;
    logic        e_rv;
    logic [15:0] e_rd;
    logic        e_rf;
    logic        e_kv;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,16'h0000,1'b0,1'b1, 1'b0,16'h0000,1'b0, 1'b1,16'h00C3,1'b0,1'b0}, // R5 R6 empty nb read
    '{1'b1,16'h1111,1'b0,1'b0, 1'b1,16'h1111,1'b0, 1'b0,16'h00C3,1'b0,1'b0}, // R1 write
    '{1'b1,16'h2222,1'b0,1'b1, 1'b1,16'h2222,1'b0, 1'b1,16'h1111,1'b1,1'b1}, // R3 R4
    '{1'b0,16'h0000,1'b1,1'b1, 1'b0,16'h0000,1'b0, 1'b1,16'h1111,1'b0,1'b1}, // R7
    '{1'b0,16'h0000,1'b0,1'b1, 1'b0,16'h0000,1'b0, 1'b1,16'h1111,1'b0,1'b1}, // R5 keeper
    '{1'b1,16'h3333,1'b0,1'b0, 1'b1,16'h3333,1'b0, 1'b0,16'h1111,1'b0,1'b1},
    '{1'b1,16'h4444,1'b0,1'b0, 1'b1,16'h3333,1'b0, 1'b0,16'h1111,1'b0,1'b1},
    '{1'b1,16'h5555,1'b0,1'b0, 1'b1,16'h3333,1'b0, 1'b0,16'h1111,1'b0,1'b1},
    '{1'b1,16'h6666,1'b0,1'b0, 1'b1,16'h3333,1'b1, 1'b0,16'h1111,1'b0,1'b1}, // R8 full
    '{1'b1,16'h7777,1'b0,1'b0, 1'b1,16'h3333,1'b1, 1'b0,16'h1111,1'b0,1'b1}, // R8 refused
    '{1'b0,16'h0000,1'b1,1'b0, 1'b1,16'h4444,1'b0, 1'b0,16'h1111,1'b0,1'b1}, // R2 R10
    '{1'b0,16'h0000,1'b1,1'b0, 1'b1,16'h5555,1'b0, 1'b0,16'h1111,1'b0,1'b1}, // R2
    '{1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h6666,1'b0, 1'b1,16'h5555,1'b1,1'b1}, // R3
    '{1'b1,16'h8888,1'b1,1'b0, 1'b1,16'h8888,1'b0, 1'b0,16'h5555,1'b1,1'b1}, // R2 push+pop
    '{1'b0,16'h0000,1'b0,1'b1, 1'b0,16'h0000,1'b0, 1'b1,16'h8888,1'b1,1'b1}, // R3 last
    '{1'b0,16'h0000,1'b0,1'b1, 1'b0,16'h0000,1'b0, 1'b1,16'h8888,1'b0,1'b1}, // R5 R4
    '{1'b0,16'h0000,1'b0,1'b0, 1'b0,16'h0000,1'b0, 1'b0,16'h8888,1'b0,1'b1}  // R9 idle
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_data = '0; bq_ready = 1'b0; nb_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    do_reset();
    // R6 reset state
    chk("R6", "bq_valid", 16'(bq_valid), 16'h0);
    chk("R6", "wr_full", 16'(wr_full), 16'h0);
    chk("R6", "keep_valid", 16'(keep_valid), 16'h0);
    chk("R9", "nb_rsp_valid", 16'(nb_rsp_valid), 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; wr_data = VEC[i].wd;
      bq_ready = VEC[i].rdy; nb_req = VEC[i].nb;
      @(negedge clk);
      chk("R1", "bq_valid", 16'(bq_valid), 16'(VEC[i].e_bv));
      if (VEC[i].e_bv) chk("R2", "bq_data", bq_data, VEC[i].e_bd);
      chk("R8", "wr_full", 16'(wr_full), 16'(VEC[i].e_full));
      chk("R9", "nb_rsp_valid", 16'(nb_rsp_valid), 16'(VEC[i].e_rv));
      chk("R3", "nb_rsp_data", nb_rsp_data, VEC[i].e_rd);
      chk("R5", "nb_rsp_fresh", 16'(nb_rsp_fresh), 16'(VEC[i].e_rf));
      chk("R4", "keep_valid", 16'(keep_valid), 16'(VEC[i].e_kv));
    end
    idle();

    // R1 stall: ready high on empty queue for several cycles
    bq_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", "bq_valid stalled", 16'(bq_valid), 16'h0);
    end
    bq_ready = 1'b0; wr_en = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk);
    idle();
    chk("R1", "bq_valid after write", 16'(bq_valid), 16'h1);
    chk("R1", "bq_data after write", bq_data, 16'hBEEF);

    // R8 fill, then write with simultaneous blocking dequeue while full
    for (int k = 0; k < D - 1; k++) begin
      wr_en = 1'b1; wr_data = 16'hA000 + 16'(k);
      @(negedge clk);
    end
    chk("R8", "wr_full after fill", 16'(wr_full), 16'h1);
    wr_en = 1'b1; wr_data = 16'hFFFF; bq_ready = 1'b1;
    @(negedge clk);
    idle();
    chk("R8", "full after pop", 16'(wr_full), 16'h0);
    chk("R2", "head after pop", bq_data, 16'hA000);
    bq_ready = 1'b1;
    for (int k = 0; k < D - 1; k++) begin
      chk("R8", "drain order", bq_data, 16'hA000 + 16'(k));
      @(negedge clk);
    end
    bq_ready = 1'b0;
    chk("R8", "refused write absent", 16'(bq_valid), 16'h0);
    chk("R10", "keeper untouched", 16'(keep_valid), 16'h1);

    // R6 second reset restores keeper value
    do_reset();
    chk("R6", "keep_valid after reset", 16'(keep_valid), 16'h0);
    nb_req = 1'b1;
    @(negedge clk);
    idle();
    chk("R6", "nb reset keeper", nb_rsp_data, KRST);
    chk("R6", "nb fresh", 16'(nb_rsp_fresh), 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule